// File: doc/BRIEF.md
# Oversampled Serial Byte Decoder

This block recovers 8-bit characters from a one-bit line that delivers one sample on each clock. It behaves like an asynchronous serial receiver whose bit period spans 2N clock ticks. N is fixed at elaboration through the `HALF_TICKS` parameter. While idle, the line is held high. A character opens with a high-to-low transition. The block then counts ticks from that transition and picks one sample near the middle of each data bit. It assembles the bits with the least significant bit first.

The completed character appears on an 8-bit output word for exactly one clock cycle. On every other cycle the word reads zero, so a non-zero output is the only sign of delivery. For that reason a character of value 0x00 makes no visible output. The block does not check the stop bit or parity and does not buffer characters. After each character it goes straight back to looking for the next falling transition.

Top module: `tick_char_decoder`

## Requirements
- R1: While reset is held and on the cycle after it is released, `charOut` is zero. Reset treats the previous sample as low, so a 0 sampled directly after reset is not a start, even if the line was high during reset.
- R2: While searching, a start is detected on the first clock edge that samples `sampleIn`=0 when the previously sampled value was 1.
- R3: The least significant data bit is the sample taken 3·N clock edges after the start sample. The 3·N−1 samples in between have no effect.
- R4: Data bit k (0..7) is the sample taken 3·N + 2·N·k clock edges after the start sample. Every other sample inside the character has no effect on the result.
- R5: Data bit k is placed at bit position k of `charOut`: bit 0 is the least significant bit and bit 7 the most significant.
- R6: The assembled byte shows on `charOut` during the cycle after the clock edge that samples bit 7. `charOut` is zero on the next cycle and on every cycle that is not a delivery.
- R7: After bit 7 the block searches again, and the previous sample is treated as low. Low samples after bit 7 therefore start nothing, even when bit 7 was 1, until the line has gone high and then low again.
- R8: A high-to-low transition that arrives while a character is being collected neither restarts nor shifts the bit timing.
- R9: A character of value 0x00 produces no non-zero output, yet it still takes up its full duration. A character that follows it is decoded normally.
- R10: A single high sample after bit 7, followed by a low sample, is enough to start the next character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one line sample per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sampleIn | input | 1 | Serial line sample |
| charOut | output | 8 | Completed character for one cycle, otherwise zero |

## Verification
Two instances, one with N=1 and one with N=2, each receive a stream that opens with the two-character reference sequence, which decodes to 0x48 and then 0x69. That sequence fixes the basic bit timing and the bit order. Next come directed frames. One frame fills all skipped samples with alternating noise, which separates correct sampling instants and edge immunity from sampling that is off by one tick. A 0x00 frame shows that the block stays in step even though nothing is shown. A frame that ends high and drops at once shows whether the previous sample is cleared. A frame separated by a single high sample shows the shortest possible gap. Finally, an exhaustive sweep over all 255 non-zero byte values, with noise on every other frame, compares the output word on every cycle with a schedule that the bench computes arithmetically.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic capture;  // current sample is a data bit
    logic finish;   // current sample is the last data bit
  } sbdStrobe_t;

  typedef enum logic {
    ST_HUNT    = 1'b0,
    ST_COLLECT = 1'b1
  } sbdState_t;

endpackage

// File: rtl/sbd_ctrl.sv
module sbd_ctrl
  import sbd_pkg::*;
#(
  parameter int HALF_TICKS = 2,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startEdge,
  output sbdStrobe_t        strobe,
  output logic [DATA_W-1:0] bitSel,
  output logic              hunting
);

  localparam int CNT_W = $clog2(3 * HALF_TICKS);
  localparam logic [CNT_W-1:0] FIRST_GAP = CNT_W'(3 * HALF_TICKS - 1);
  localparam logic [CNT_W-1:0] NEXT_GAP  = CNT_W'(2 * HALF_TICKS - 1);
  localparam logic [DATA_W-1:0] SEL_INIT = DATA_W'(1);

  sbdState_t        state;
  logic [CNT_W-1:0] tickCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_HUNT;
      tickCnt <= '0;
      bitSel  <= SEL_INIT;
    end else begin
      case (state)
        ST_HUNT: begin
          if (startEdge) begin
            state   <= ST_COLLECT;
            tickCnt <= FIRST_GAP;
            bitSel  <= SEL_INIT;
          end
        end
        ST_COLLECT: begin
          if (tickCnt == '0) begin
            tickCnt <= NEXT_GAP;
            bitSel  <= {bitSel[DATA_W-2:0], bitSel[DATA_W-1]};
            if (bitSel[DATA_W-1]) begin
              state <= ST_HUNT;
            end
          end else begin
            tickCnt <= tickCnt - 1'b1;
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  always_comb begin
    hunting        = (state == ST_HUNT);
    strobe.capture = (state == ST_COLLECT) && (tickCnt == '0);
    strobe.finish  = strobe.capture && bitSel[DATA_W-1];
  end

  AST_BITSEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(bitSel) == 1); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    tickCnt <= FIRST_GAP); // R3
  AST_EDGE_ARMS: assert property (@(posedge clk) disable iff (rst)
    (hunting && startEdge) |=> (state == ST_COLLECT && tickCnt == FIRST_GAP)); // R2
  AST_FINISH_RETURNS: assert property (@(posedge clk) disable iff (rst)
    strobe.finish |=> hunting); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COLLECT && !strobe.capture) |=> (state == ST_COLLECT && $stable(bitSel))); // R8

endmodule

// File: rtl/sbd_datapath.sv
module sbd_datapath
  import sbd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleIn,
  input  logic              hunting,
  input  sbdStrobe_t        strobe,
  input  logic [DATA_W-1:0] bitSel,
  output logic              startEdge,
  output logic [DATA_W-1:0] dataOut
);

  logic              prevSample;
  logic [DATA_W-1:0] byteBuf;
  logic [DATA_W-1:0] nextByte;

  // Previous sample; forced low at reset and after the last bit
  always_ff @(posedge clk) begin
    if (rst || strobe.finish) begin
      prevSample <= 1'b0;
    end else begin
      prevSample <= sampleIn;
    end
  end

  assign startEdge = hunting && prevSample && !sampleIn;

  // Each bit lands in its own fixed slot, selected by a one-hot strobe
  for (genvar i = 0; i < DATA_W; i++) begin : g_slot
    assign nextByte[i] = (strobe.capture && bitSel[i]) ? sampleIn : byteBuf[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byteBuf <= '0;
      dataOut <= '0;
    end else begin
      byteBuf <= nextByte;
      dataOut <= strobe.finish ? nextByte : '0;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (dataOut != '0) |=> (dataOut == '0)); // R6
  AST_OUT_AFTER_FINISH: assert property (@(posedge clk) disable iff (rst)
    (dataOut != '0) |-> $past(strobe.finish)); // R6
  AST_PREV_LOW_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    strobe.finish |=> !startEdge); // R7

endmodule

// File: rtl/tick_char_decoder.sv
module tick_char_decoder
  import sbd_pkg::*;
#(
  parameter int HALF_TICKS = 2,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleIn,
  output logic [DATA_W-1:0] charOut
);

  sbdStrobe_t        strobe;
  logic [DATA_W-1:0] bitSel;
  logic              hunting;
  logic              startEdge;

  sbd_ctrl #(
    .HALF_TICKS(HALF_TICKS),
    .DATA_W    (DATA_W)
  ) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .startEdge(startEdge),
    .strobe   (strobe),
    .bitSel   (bitSel),
    .hunting  (hunting)
  );

  sbd_datapath #(
    .DATA_W(DATA_W)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .sampleIn (sampleIn),
    .hunting  (hunting),
    .strobe   (strobe),
    .bitSel   (bitSel),
    .startEdge(startEdge),
    .dataOut  (charOut)
  );

endmodule

// File: tb/tick_char_decoder_tb_top.sv
module tick_char_decoder_tb_top;

  localparam int MAXL = 12000;

  logic       clk = 1'b0;
  logic       rst;
  logic       sInA, sInB;
  logic [7:0] outA, outB;

  always #10 clk = ~clk;

  tick_char_decoder #(.HALF_TICKS(1), .DATA_W(8)) dut_i (
    .clk(clk), .rst(rst), .sampleIn(sInA), .charOut(outA));
  tick_char_decoder #(.HALF_TICKS(2), .DATA_W(8)) dutB_i (
    .clk(clk), .rst(rst), .sampleIn(sInB), .charOut(outB));

  bit         strm [2][MAXL];
  logic [7:0] expv [2][MAXL];
  string      tagv [2][MAXL];
  int         len  [2];
  int         checks = 0;
  int         errors = 0;

  task automatic pushBit(int d, bit b);
    strm[d][len[d]] = b;
    expv[d][len[d]] = 8'h00;
    tagv[d][len[d]] = "R6";
    len[d]++;
  endtask

  task automatic pushRun(int d, int n, bit b);
    for (int i = 0; i < n; i++) pushBit(d, b);
  endtask

  // Edge sample, then 17N samples; bit k sits at offset 3N+2Nk
  task automatic pushFrame(int d, logic [7:0] v, bit noise, string tag);
    int n = d + 1;
    pushBit(d, 1'b0);
    for (int t = 1; t <= 17 * n; t++) begin
      bit b;
      if (t >= 3 * n && ((t - 3 * n) % (2 * n)) == 0) b = v[(t - 3 * n) / (2 * n)];
      else if (noise) b = ((t % 2) == 1);
      else if (t < 3 * n) b = 1'b0;
      else b = v[(t - 3 * n) / (2 * n)];
      pushBit(d, b);
    end
    expv[d][len[d] - 1] = v;
    tagv[d][len[d] - 1] = tag;
  endtask

  task automatic chk(string tag, int d, int i, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s dut N=%0d cycle %0d: actual %h expected %h", tag, d + 1, i, act, exp);
    end
  endtask

  initial begin
    len[0] = 0;
    len[1] = 0;
    for (int d = 0; d < 2; d++) begin
      int n = d + 1;
      pushRun(d, 3, 1'b0);                       // R1: lows right after reset
      pushRun(d, 2 * n + 1, 1'b1);               // reference stream
      pushFrame(d, 8'h48, 1'b0, "R3");
      pushRun(d, 2 * n + 1, 1'b1);
      pushFrame(d, 8'h69, 1'b0, "R5");
      pushRun(d, 2 * n + 1, 1'b1);
      pushFrame(d, 8'hA5, 1'b1, "R8");           // noise in skipped samples
      pushRun(d, 2 * n, 1'b1);
      pushFrame(d, 8'h00, 1'b0, "R9");           // invisible character
      pushRun(d, 2 * n, 1'b1);
      pushFrame(d, 8'h81, 1'b0, "R9");
      pushRun(d, 2 * n, 1'b1);
      pushFrame(d, 8'h80, 1'b0, "R7");           // bit7=1 then low
      pushRun(d, 3, 1'b0);
      pushRun(d, 2 * n, 1'b1);
      pushFrame(d, 8'h3C, 1'b0, "R7");
      pushRun(d, 2 * n, 1'b1);
      pushFrame(d, 8'h55, 1'b0, "R10");          // one-sample gap
      pushBit(d, 1'b1);
      pushFrame(d, 8'hC3, 1'b0, "R10");
      for (int v = 1; v < 256; v++) begin        // exhaustive sweep
        pushRun(d, 2 * n, 1'b1);
        pushFrame(d, 8'(v), (v % 2) == 1, "R4");
      end
      pushRun(d, 2 * n, 1'b1);
    end
    while (len[0] < len[1]) pushBit(0, 1'b1);
    while (len[1] < len[0]) pushBit(1, 1'b1);

    rst  = 1'b1;
    sInA = 1'b1;
    sInB = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", 0, -1, outA, 8'h00);
    chk("R1", 1, -1, outB, 8'h00);
    rst = 1'b0;
    for (int i = 0; i < len[0]; i++) begin
      sInA = strm[0][i];
      sInB = strm[1][i];
      @(negedge clk);
      chk(tagv[0][i], 0, i, outA, expv[0][i]);
      chk(tagv[1][i], 1, i, outB, expv[1][i]);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule